// File: doc/BRIEF.md
# Traceback Survivor Memory

This block sits behind the add-compare-select array of a 64-state Viterbi decoder. Each trellis stage delivers two 32-bit decision words, and the block stores them in a 512-word synchronous RAM. That RAM is organised as four banks of 64 stages. Storage never pauses: a word may arrive on any cycle, including cycles in which the RAM is being read for a traceback.

Each time a bank fills, and once two banks are complete, the block runs a traceback. It starts from the state the caller names for the final stage of the newest bank. It first walks back through that whole bank without emitting anything, so that the path can settle on the surviving route. It then walks through the bank before it. The bits recovered there come out newest first. They are placed in a 64-entry reversal buffer and leave the block serially, oldest stage first, with a valid strobe.

Each traceback covers 128 stages at one stage per cycle, so the tracer keeps pace with a writer that never stops. The last step of one pass shares its cycle with the first read of the next pass.

Top module: `traceback_survivor_mem`

## Requirements
- R1: After reset validOut is low. No decoded bit is emitted until two complete blocks of 64 stages have been written since the most recent reset.
- R2: Stage s occupies word addresses 2s and 2s+1 (mod 512) in write order. The decision for state j of that stage is bit j[4:0] of word 2s+j[5]. A set decision bit means the predecessor state has a top bit of 1.
- R3: One trace step from state j reads that state's decision d. It takes {d, j[5:1]} as the predecessor state and yields j[0] as the decoded bit of the stage.
- R4: Writing the last word of a block (address low 7 bits all ones) triggers a trace when at least two blocks are then complete. startState is sampled only in that write cycle and names the state at the block's final stage.
- R5: The 64 stages of the newest block are traced without output. When all paths merge within 64 stages, any start state gives the correct bits.
- R6: Each trace emits the 64 decoded bits of the block before the newest, oldest stage first, one bit per cycle with validOut high.
- R7: Decision words may be written on every cycle, including cycles in which the tracer reads, and a trace never reads the bank being written.
- R8: Every triggering block yields exactly one burst, even when words arrive on every cycle without gaps.
- R9: validOut stays high for exactly 64 consecutive cycles in each burst.
- R10: With the tracer idle, the first bit of a burst is valid 129 clock cycles after the edge that stores the triggering word.
- R11: Word addresses wrap from 511 to 0, and decoding stays correct across the wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| decWord | input | 32 | Decision word for one half of a stage's states |
| decWrite | input | 1 | Stores decWord at the next write address |
| startState | input | 6 | Trace start state, sampled with a block's last word |
| bitOut | output | 1 | Decoded bit, meaningful while validOut is high |
| validOut | output | 1 | Marks each cycle carrying a decoded bit |

## Verification
Two things can fall in the same cycle: a decision write and a traceback read. Streaming decision words back to back forces every trace to run while the next bank is being filled. It also makes the final step of one trace coincide with the first read of the next. These runs are judged by comparing every emitted bit with the input sequence that built the decisions, and by requiring one burst of exactly 64 bits per triggering block. Sparse streams, streams that wrap the RAM, deliberately wrong start states over merging decision patterns, and a reset in the middle of a trace complete the picture.

// File: rtl/tbsm_pkg.sv
package tbsm_pkg;
  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture; // block finished: latch the start state
    logic load;    // begin a pass from the latched start state
    logic step;    // one trace step this cycle
    logic keep;    // decode phase: store the decoded bit
    logic read;    // RAM read issued this cycle
  } tbsm_ctl_t;
endpackage

// File: rtl/tbsm_ram.sv
module tbsm_ram #(
  parameter int WORD_W = 32,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [WORD_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [WORD_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrAddr] <= wrData;
    if (rdEn) rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/tbsm_ctrl.sv
module tbsm_ctrl
  import tbsm_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int SLICE_W = 1,
  parameter int BLOCK_W = 6
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      decWrite,
  output logic [ADDR_W-1:0]         wrAddr,
  output tbsm_ctl_t                 ctl,
  output logic [ADDR_W-SLICE_W-1:0] rdStage,
  output logic [BLOCK_W-1:0]        keepIdx,
  output logic [BLOCK_W-1:0]        outIdx,
  output logic                      outActive
);
  localparam int STAGE_W = ADDR_W - SLICE_W;
  localparam int SUB_W   = SLICE_W + BLOCK_W;
  localparam int BANK_W  = ADDR_W - SUB_W;
  localparam int STEP_W  = BLOCK_W + 1;
  localparam logic [ADDR_W-1:0]  ONE_ADDR  = 1;
  localparam logic [STAGE_W-1:0] ONE_STAGE = 1;
  localparam logic [STEP_W-1:0]  ONE_STEP  = 1;
  localparam logic [BLOCK_W-1:0] ONE_OUT   = 1;

  logic               haveOne, pend, busy;
  logic [STAGE_W-1:0] pendStage, stageIdx;
  logic [STEP_W-1:0]  stepCnt;
  logic               blockDone, trigger, lastStep, start;

  assign blockDone = decWrite && (&wrAddr[SUB_W-1:0]);
  assign trigger   = blockDone && haveOne;
  assign lastStep  = busy && (&stepCnt);
  // the next pass may reuse the final step cycle, which needs no read
  assign start     = pend && (!busy || lastStep);

  always_comb begin
    ctl.capture = trigger;
    ctl.load    = start;
    ctl.step    = busy;
    ctl.keep    = busy && stepCnt[BLOCK_W];
    ctl.read    = start || (busy && !lastStep);
  end

  assign rdStage = start ? pendStage : stageIdx - ONE_STAGE;
  assign keepIdx = stageIdx[BLOCK_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAddr  <= '0;
      haveOne <= 1'b0;
    end else if (decWrite) begin
      wrAddr <= wrAddr + ONE_ADDR;
      if (blockDone) haveOne <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pend      <= 1'b0;
      pendStage <= '0;
    end else if (trigger) begin
      pend      <= 1'b1;
      pendStage <= wrAddr[ADDR_W-1:SLICE_W];
    end else if (start) begin
      pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy     <= 1'b0;
      stepCnt  <= '0;
      stageIdx <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      stepCnt  <= '0;
      stageIdx <= pendStage;
    end else if (busy) begin
      stepCnt  <= stepCnt + ONE_STEP;
      stageIdx <= stageIdx - ONE_STAGE;
      if (lastStep) busy <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outActive <= 1'b0;
      outIdx    <= '0;
    end else if (lastStep) begin
      outActive <= 1'b1;
      outIdx    <= '0;
    end else if (outActive) begin
      outIdx <= outIdx + ONE_OUT;
      if (&outIdx) outActive <= 1'b0;
    end
  end

  // R7: a read never targets the bank being filled
  assert_no_bank_clash_R7: assert property (@(posedge clk) disable iff (!rstN)
    (decWrite && ctl.read) |-> (wrAddr[ADDR_W-1 -: BANK_W] != rdStage[STAGE_W-1 -: BANK_W]));

  // R8: a new trigger never lands on an unconsumed one
  assert_no_lost_trigger_R8: assert property (@(posedge clk) disable iff (!rstN)
    trigger |-> !pend);

  // R9: a burst does not break before its 64th bit
  assert_burst_unbroken_R9: assert property (@(posedge clk) disable iff (!rstN)
    (outActive && !(&outIdx)) |=> outActive);

  // R1: output only after two complete blocks
  assert_out_after_two_R1: assert property (@(posedge clk) disable iff (!rstN)
    outActive |-> haveOne);
endmodule

// File: rtl/tbsm_dp.sv
module tbsm_dp
  import tbsm_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int ADDR_W  = 9,
  parameter int SLICE_W = 1,
  parameter int BLOCK_W = 6,
  localparam int STATE_W = $clog2(WORD_W) + SLICE_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  tbsm_ctl_t                 ctl,
  input  logic [STATE_W-1:0]        startState,
  input  logic [WORD_W-1:0]         rdData,
  input  logic [ADDR_W-SLICE_W-1:0] rdStage,
  input  logic [BLOCK_W-1:0]        keepIdx,
  input  logic [BLOCK_W-1:0]        outIdx,
  input  logic                      outActive,
  output logic [ADDR_W-1:0]         rdAddr,
  output logic                      rdEn,
  output logic                      bitOut,
  output logic                      validOut
);
  localparam int LOW_W = STATE_W - SLICE_W;
  localparam int SEG   = 1 << BLOCK_W;

  logic [STATE_W-1:0] pendState, curState, nextState;
  logic               decBit;
  logic [SEG-1:0]     keepBuf;

  // survivor step: decision bit enters at the top, decoded bit leaves at the bottom
  assign decBit    = rdData[curState[LOW_W-1:0]];
  assign nextState = {decBit, curState[STATE_W-1:1]};

  assign rdAddr = ctl.load ? {rdStage, pendState[STATE_W-1 -: SLICE_W]}
                           : {rdStage, nextState[STATE_W-1 -: SLICE_W]};
  assign rdEn   = ctl.read;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendState <= '0;
    else if (ctl.capture) pendState <= startState;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= '0;
    else if (ctl.load) curState <= pendState;
    else if (ctl.step) curState <= nextState;
  end

  // reversal buffer: written by stage offset going down, drained going up
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) keepBuf <= '0;
    else if (ctl.keep) keepBuf[keepIdx] <= curState[0];
  end

  assign bitOut   = keepBuf[outIdx];
  assign validOut = outActive;

  // R3: each step keeps the upper bits of the state as the lower bits of its predecessor
  assert_pred_shift_R3: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !ctl.load) |=> (curState[STATE_W-2:0] == $past(curState[STATE_W-1:1])));
endmodule

// File: rtl/traceback_survivor_mem.sv
module traceback_survivor_mem
  import tbsm_pkg::*;
#(
  parameter int WORD_W  = 32,
  parameter int ADDR_W  = 9,
  parameter int SLICE_W = 1,
  parameter int BLOCK_W = 6,
  localparam int STATE_W = $clog2(WORD_W) + SLICE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [WORD_W-1:0]  decWord,
  input  logic               decWrite,
  input  logic [STATE_W-1:0] startState,
  output logic               bitOut,
  output logic               validOut
);
  localparam int STAGE_W = ADDR_W - SLICE_W;

  tbsm_ctl_t          ctl;
  logic [ADDR_W-1:0]  wrAddr, rdAddr;
  logic [STAGE_W-1:0] rdStage;
  logic [BLOCK_W-1:0] keepIdx, outIdx;
  logic               outActive, rdEn;
  logic [WORD_W-1:0]  rdData;

  tbsm_ctrl #(.ADDR_W(ADDR_W), .SLICE_W(SLICE_W), .BLOCK_W(BLOCK_W)) uCtrl (
    .clk(clk), .rstN(rstN), .decWrite(decWrite), .wrAddr(wrAddr), .ctl(ctl),
    .rdStage(rdStage), .keepIdx(keepIdx), .outIdx(outIdx), .outActive(outActive)
  );

  tbsm_dp #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .SLICE_W(SLICE_W), .BLOCK_W(BLOCK_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .startState(startState), .rdData(rdData),
    .rdStage(rdStage), .keepIdx(keepIdx), .outIdx(outIdx), .outActive(outActive),
    .rdAddr(rdAddr), .rdEn(rdEn), .bitOut(bitOut), .validOut(validOut)
  );

  tbsm_ram #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) uRam (
    .clk(clk), .wrEn(decWrite), .wrAddr(wrAddr), .wrData(decWord),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: tb/sim_traceback_survivor_mem.sv
module sim_traceback_survivor_mem;
  localparam int CLK_PERIOD = 10;
  localparam int NSTG = 384;
  // row: seed[35:20] blocks[19:16] gap[15:12] noisy[11:8] wrongStart[7:4] bursts[3:0]
  localparam logic [35:0] VEC [5] = '{
    {16'h1ACE, 4'd4, 4'd0, 4'd1, 4'd0, 4'd3},
    {16'h5EED, 4'd4, 4'd1, 4'd0, 4'd1, 4'd3},
    {16'h0F0F, 4'd6, 4'd0, 4'd1, 4'd0, 4'd5},
    {16'h7777, 4'd5, 4'd3, 4'd0, 4'd1, 4'd4},
    {16'h1234, 4'd6, 4'd0, 4'd0, 4'd1, 4'd5}
  };

  logic clk = 1'b0, rstN = 1'b0, decWrite = 1'b0;
  logic [31:0] decWord = '0;
  logic [5:0] startState = '0;
  logic bitOut, validOut;

  always #(CLK_PERIOD/2) clk = ~clk;

  traceback_survivor_mem u0 (
    .clk(clk), .rstN(rstN), .decWord(decWord), .decWrite(decWrite),
    .startState(startState), .bitOut(bitOut), .validOut(validOut)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [5:0] st [NSTG];
  logic recvBits [512];
  int recvCnt = 0, burstCnt = 0, badRun = 0, runLen = 0;
  logic prevV = 1'b0;

  always @(negedge clk) begin
    if (!rstN) begin
      recvCnt = 0; burstCnt = 0; badRun = 0; runLen = 0; prevV = 1'b0;
    end else begin
      if (validOut) begin
        if (!prevV) burstCnt++;
        if (recvCnt < 512) recvBits[recvCnt] = bitOut;
        recvCnt++;
        runLen++;
      end else if (prevV) begin
        if (runLen != 64) badRun++;
        runLen = 0;
      end
      prevV = validOut;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] nxt(input logic [15:0] x);
    return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
  endfunction

  task automatic doReset();
    rstN = 1'b0; decWrite = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic put(input logic [31:0] w, input logic [5:0] sv, input int gap);
    decWord = w; startState = sv; decWrite = 1'b1;
    @(negedge clk);
    if (gap > 0) begin
      decWrite = 1'b0;
      repeat (gap) @(negedge clk);
    end
  endtask

  // builds a path from an input bit stream and writes decisions per R2
  task automatic stream(input logic [15:0] seed, input int nb, input int gap, input bit noisy, input bit wrong);
    logic [15:0] r = seed;
    logic [15:0] g = seed ^ 16'hA5A5;
    logic [5:0] prev = '0;
    for (int s = 0; s < nb * 64; s++) begin
      r = nxt(r);
      st[s] = {prev[4:0], r[0]};
      for (int h = 0; h < 2; h++) begin
        logic [31:0] w;
        logic [5:0] sv;
        for (int i = 0; i < 32; i++) begin
          if (!noisy || (6'(h * 32 + i) == st[s])) w[i] = prev[5];
          else begin r = nxt(r); w[i] = r[3]; end
        end
        g = nxt(g);
        sv = g[5:0];
        if (h == 1 && (s % 64) == 63) sv = wrong ? (st[s] ^ 6'h2A) : st[s];
        put(w, sv, gap);
      end
      prev = st[s];
    end
    decWrite = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL R8 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    doReset();
    check(validOut == 1'b0, "R1 reset validOut", 64'(validOut), 64'd0);

    for (int v = 0; v < 5; v++) begin
      int nb, gp, eb;
      nb = int'(VEC[v][19:16]);
      gp = int'(VEC[v][15:12]);
      eb = int'(VEC[v][3:0]);
      doReset();
      stream(VEC[v][35:20], nb, gp, VEC[v][8], VEC[v][4]);
      repeat (300) @(negedge clk);
      check(recvCnt == eb * 64, "R8 bit count", 64'(recvCnt), 64'(eb * 64));
      check(burstCnt == eb, "R8 burst count", 64'(burstCnt), 64'(eb));
      check(badRun == 0 && runLen == 0, "R9 burst length", 64'(badRun), 64'd0);
      for (int k = 0; k < eb; k++) begin
        logic [63:0] got, exp;
        for (int i = 0; i < 64; i++) begin
          got[i] = recvBits[k * 64 + i];
          exp[i] = st[k * 64 + i][0];
        end
        check(got == exp, "R2 R3 R4 R5 R6 R7 R11 block data", got, exp);
      end
    end

    // R1: one block alone produces nothing
    doReset();
    stream(16'h3C3C, 1, 0, 1'b0, 1'b0);
    repeat (400) @(negedge clk);
    check(recvCnt == 0, "R1 single block silent", 64'(recvCnt), 64'd0);

    // R10: latency from the triggering write to the first bit
    doReset();
    stream(16'h4242, 2, 0, 1'b1, 1'b0);
    begin
      int n = 0;
      while (!validOut && n < 400) begin
        @(negedge clk);
        n++;
      end
      check(n == 129, "R10 first bit latency", 64'(n), 64'd129);
    end
    repeat (100) @(negedge clk);

    // R1: reset during a trace discards it and restarts block counting
    doReset();
    stream(16'h6161, 2, 0, 1'b1, 1'b0);
    repeat (50) @(negedge clk);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (300) @(negedge clk);
    check(recvCnt == 0 && validOut == 1'b0, "R1 reset mid trace", 64'(recvCnt), 64'd0);
    stream(16'h7A7A, 1, 0, 1'b1, 1'b0);
    repeat (300) @(negedge clk);
    check(recvCnt == 0, "R1 count restarts after reset", 64'(recvCnt), 64'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule